// File: doc/BRIEF.md
# Debug Exception Entry Controller

This block decides when a processor core leaves normal execution for debug mode, and where it starts fetching when it does. It watches three request sources. The first is single-step, which fires after an instruction retires while the step-enable control is set. The second is a software breakpoint instruction reaching retirement. The third is a break request held as a level by the JTAG-side control logic. When it accepts a request, the block captures the PC that the pipeline supplies into a saved debug PC register. It also records the cause as a one-hot field, raises the debug-mode flag, pulses a take-exception strobe and presents the handler address.

While the flag is set, the block masks interrupts and accepts no further debug requests. An NMI that arrives in that window is held internally and delivered after the handler returns. A return strobe clears the flag and pulses a resume indication; the fetch unit then uses the saved debug PC as its target. A real-time mode input leaves only the JTAG break able to cause entry. A probe-enable input chooses between two handler addresses.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: After reset, debugMode, takeExc, nmiTake and resumeTake are 0, and savedPc, causeOut and vector are all 0.
- R2: When stepEnable and retireValid are both 1 and debug mode is clear, takeExc pulses for one cycle in the next cycle. In that same cycle debugMode becomes 1 and causeOut equals 3'b001 (bit 0 means single step).
- R3: When bpExec and retireValid are both 1 and debug mode is clear, entry occurs with causeOut equal to 3'b010 (bit 1 means breakpoint instruction).
- R4: When jtagBreak is 1 and debug mode is clear, entry occurs with causeOut equal to 3'b100 (bit 2 means JTAG break), whatever the state of rtMode or retireValid.
- R5: When several causes request in the same cycle, JTAG break wins over the breakpoint instruction, which wins over single step. causeOut holds only the winner's bit.
- R6: While rtMode is 1, single-step and breakpoint requests cause no entry.
- R7: On entry, savedPc takes the retirePc value of the request cycle.
- R8: On entry, vector becomes 64'hFFFF_FFFF_FF20_0200 if probeEnable was 1 in the request cycle, or 64'hFFFF_FFFF_BFC0_0400 if it was 0.
- R9: While debug mode is set, new requests are ignored: no takeExc, and savedPc, causeOut and vector are unchanged.
- R10: Outside debug mode, an nmiIn pulse with no debug entry in the same cycle gives a one-cycle nmiTake in the next cycle.
- R11: An nmiIn pulse that arrives while debug mode is set, or in the cycle of an entry, gives no nmiTake while debug mode is set. It gives exactly one nmiTake one cycle after debugMode clears.
- R12: dbgReturn while in debug mode clears debugMode and pulses resumeTake in the next cycle. savedPc keeps the resume address.
- R13: A jtagBreak held at 1 through a return causes a new entry in the cycle after debugMode clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| stepEnable | input | 1 | Single-step enable control bit |
| bpExec | input | 1 | Breakpoint instruction is retiring |
| retireValid | input | 1 | An instruction retires this cycle |
| retirePc | input | 64 | PC to save on entry |
| jtagBreak | input | 1 | Break request level from the JTAG control register |
| rtMode | input | 1 | Real-time debugging active |
| probeEnable | input | 1 | Selects the probe handler address |
| nmiIn | input | 1 | NMI request strobe |
| dbgReturn | input | 1 | Debug handler return strobe |
| takeExc | output | 1 | One-cycle debug entry pulse |
| vector | output | 64 | Handler address chosen at entry |
| debugMode | output | 1 | Debug-mode flag |
| savedPc | output | 64 | Saved debug PC, used as the resume address |
| causeOut | output | 3 | One-hot cause of the last entry |
| nmiTake | output | 1 | One-cycle NMI delivery pulse |
| resumeTake | output | 1 | One-cycle return-to-savedPc pulse |

## Verification
Every result is registered once. Entry, NMI delivery and resume show up one cycle after the cycle in which they are requested. A latched NMI appears one cycle after the cycle in which debugMode reads 0 again, so it arrives two cycles after the return strobe. The driver applies each cycle's inputs on the falling edge and then pushes the result it expects after the following rising edge. The monitor pops and compares exactly one item shortly after each rising edge, so every comparison lands in the cycle where the result becomes due.

// File: rtl/dbgent_pkg.sv
package dbgent_pkg;
  localparam int NUM_CAUSE  = 3;
  localparam int CAUSE_STEP = 0;
  localparam int CAUSE_BRK  = 1;
  localparam int CAUSE_JTAG = 2;

  typedef struct packed {
    logic                 enter;
    logic [NUM_CAUSE-1:0] cause;
    logic                 useProbeVec;
  } dbgStrobe_t;
endpackage

// File: rtl/dbgent_ctrl.sv
module dbgent_ctrl
  import dbgent_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepEnable,
  input  logic       bpExec,
  input  logic       retireValid,
  input  logic       jtagBreak,
  input  logic       rtMode,
  input  logic       probeEnable,
  input  logic       nmiIn,
  input  logic       dbgReturn,
  output dbgStrobe_t strobe,
  output logic       takeExc,
  output logic       debugMode,
  output logic       nmiTake,
  output logic       resumeTake
);
  logic [NUM_CAUSE-1:0] reqVec;
  logic [NUM_CAUSE-1:0] grant;
  logic dbgQ, takeQ, nmiTakeQ, resumeQ, nmiPendQ;
  logic entryNow, nmiSeen, nmiGo, leaveNow;

  always_comb begin
    reqVec             = '0;
    reqVec[CAUSE_STEP] = stepEnable & retireValid & ~rtMode;
    reqVec[CAUSE_BRK]  = bpExec & retireValid & ~rtMode;
    reqVec[CAUSE_JTAG] = jtagBreak;
  end

  // highest index wins: JTAG, then breakpoint, then step
  always_comb begin
    grant = '0;
    for (int i = 0; i < NUM_CAUSE; i++) begin
      if (reqVec[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign entryNow = ~dbgQ & (|reqVec);
  assign leaveNow = dbgQ & dbgReturn;
  assign nmiSeen  = nmiPendQ | nmiIn;
  assign nmiGo    = ~dbgQ & ~entryNow & nmiSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dbgQ     <= 1'b0;
      takeQ    <= 1'b0;
      nmiTakeQ <= 1'b0;
      resumeQ  <= 1'b0;
      nmiPendQ <= 1'b0;
    end else begin
      if (entryNow)      dbgQ <= 1'b1;
      else if (leaveNow) dbgQ <= 1'b0;
      takeQ    <= entryNow;
      resumeQ  <= leaveNow;
      nmiTakeQ <= nmiGo;
      nmiPendQ <= nmiSeen & ~nmiGo;
    end
  end

  assign strobe.enter       = entryNow;
  assign strobe.cause       = grant;
  assign strobe.useProbeVec = probeEnable;
  assign takeExc    = takeQ;
  assign debugMode  = dbgQ;
  assign nmiTake    = nmiTakeQ;
  assign resumeTake = resumeQ;

  // R2
  take_sets_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> debugMode);
  // R4
  jtag_enters_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!debugMode && jtagBreak) |=> takeExc);
  // R11
  nmi_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiTake |-> !debugMode);
  // R12
  return_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (debugMode && dbgReturn) |=> (!debugMode && resumeTake));
endmodule

// File: rtl/dbgent_dpath.sv
module dbgent_dpath
  import dbgent_pkg::*;
#(
  parameter int              PC_W      = 64,
  parameter logic [PC_W-1:0] VEC_PROBE = 64'hFFFF_FFFF_FF20_0200,
  parameter logic [PC_W-1:0] VEC_ROM   = 64'hFFFF_FFFF_BFC0_0400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dbgStrobe_t           strobe,
  input  logic                 debugModeIn,
  input  logic [PC_W-1:0]      retirePc,
  output logic [PC_W-1:0]      savedPc,
  output logic [NUM_CAUSE-1:0] causeOut,
  output logic [PC_W-1:0]      vector
);
  logic [PC_W-1:0]      depcQ, vecQ;
  logic [NUM_CAUSE-1:0] causeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depcQ  <= '0;
      causeQ <= '0;
      vecQ   <= '0;
    end else if (strobe.enter) begin
      depcQ  <= retirePc;
      causeQ <= strobe.cause;
      vecQ   <= strobe.useProbeVec ? VEC_PROBE : VEC_ROM;
    end
  end

  assign savedPc  = depcQ;
  assign causeOut = causeQ;
  assign vector   = vecQ;

  // R9
  depc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    debugModeIn |=> ($stable(depcQ) && $stable(causeQ)));
  // R5
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> $onehot(causeQ));
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbgent_pkg::*;
#(
  parameter int              PC_W      = 64,
  parameter logic [PC_W-1:0] VEC_PROBE = 64'hFFFF_FFFF_FF20_0200,
  parameter logic [PC_W-1:0] VEC_ROM   = 64'hFFFF_FFFF_BFC0_0400
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stepEnable,
  input  logic                 bpExec,
  input  logic                 retireValid,
  input  logic [PC_W-1:0]      retirePc,
  input  logic                 jtagBreak,
  input  logic                 rtMode,
  input  logic                 probeEnable,
  input  logic                 nmiIn,
  input  logic                 dbgReturn,
  output logic                 takeExc,
  output logic [PC_W-1:0]      vector,
  output logic                 debugMode,
  output logic [PC_W-1:0]      savedPc,
  output logic [NUM_CAUSE-1:0] causeOut,
  output logic                 nmiTake,
  output logic                 resumeTake
);
  dbgStrobe_t strobe;

  dbgent_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stepEnable(stepEnable), .bpExec(bpExec),
    .retireValid(retireValid), .jtagBreak(jtagBreak), .rtMode(rtMode),
    .probeEnable(probeEnable), .nmiIn(nmiIn), .dbgReturn(dbgReturn),
    .strobe(strobe), .takeExc(takeExc), .debugMode(debugMode),
    .nmiTake(nmiTake), .resumeTake(resumeTake)
  );

  dbgent_dpath #(.PC_W(PC_W), .VEC_PROBE(VEC_PROBE), .VEC_ROM(VEC_ROM)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .debugModeIn(debugMode),
    .retirePc(retirePc), .savedPc(savedPc), .causeOut(causeOut), .vector(vector)
  );

  // R8
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeExc |-> (vector == VEC_PROBE || vector == VEC_ROM));
endmodule

// File: tb/sim_dbg_entry_ctrl.sv
`timescale 1ns/100ps
module sim_dbg_entry_ctrl;
  localparam logic [63:0] VP = 64'hFFFF_FFFF_FF20_0200;
  localparam logic [63:0] VR = 64'hFFFF_FFFF_BFC0_0400;

  logic clk = 1'b0, rstN = 1'b0;
  logic stepEnable = 0, bpExec = 0, retireValid = 0, jtagBreak = 0;
  logic rtMode = 0, probeEnable = 0, nmiIn = 0, dbgReturn = 0;
  logic [63:0] retirePc = '0;
  logic takeExc, debugMode, nmiTake, resumeTake;
  logic [63:0] vector, savedPc;
  logic [2:0] causeOut;

  int testCnt = 0, failCnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbg_entry_ctrl u0 (
    .clk(clk), .rstN(rstN), .stepEnable(stepEnable), .bpExec(bpExec),
    .retireValid(retireValid), .retirePc(retirePc), .jtagBreak(jtagBreak),
    .rtMode(rtMode), .probeEnable(probeEnable), .nmiIn(nmiIn),
    .dbgReturn(dbgReturn), .takeExc(takeExc), .vector(vector),
    .debugMode(debugMode), .savedPc(savedPc), .causeOut(causeOut),
    .nmiTake(nmiTake), .resumeTake(resumeTake)
  );

  typedef struct {
    logic        take, dbg, nmiT, res;
    logic [63:0] depc, vec;
    logic [2:0]  cause;
    string       tag;
  } exp_t;
  exp_t q[$];

  // reference state, from the requirements
  logic        mDbg = 0, mPend = 0;
  logic [63:0] mDepc = '0, mVec = '0;
  logic [2:0]  mCause = '0;

  task automatic check(exp_t e);
    testCnt++;
    if (takeExc !== e.take || debugMode !== e.dbg || nmiTake !== e.nmiT ||
        resumeTake !== e.res || savedPc !== e.depc || vector !== e.vec ||
        causeOut !== e.cause) begin
      failCnt++;
      $display("FAIL %s: act take=%b dbg=%b nmi=%b res=%b pc=%h vec=%h cause=%b exp take=%b dbg=%b nmi=%b res=%b pc=%h vec=%h cause=%b",
        e.tag, takeExc, debugMode, nmiTake, resumeTake, savedPc, vector, causeOut,
        e.take, e.dbg, e.nmiT, e.res, e.depc, e.vec, e.cause);
    end
  endtask

  task automatic step(input logic ss, bp, rv, jt, rt, pe, nmi, ret,
                      input logic [63:0] pc, input string tag);
    exp_t e;
    logic entry, take;
    @(negedge clk);
    stepEnable = ss; bpExec = bp; retireValid = rv; jtagBreak = jt;
    rtMode = rt; probeEnable = pe; nmiIn = nmi; dbgReturn = ret; retirePc = pc;
    entry = !mDbg && (jt || (rv && !rt && (bp || ss)));
    e.res = mDbg && ret;
    take  = !mDbg && !entry && (mPend || nmi);
    mPend = (mPend || nmi) && !take;
    if (entry) begin
      mDbg = 1; mDepc = pc; mVec = pe ? VP : VR;
      mCause = jt ? 3'b100 : (bp && rv && !rt) ? 3'b010 : 3'b001;
    end else if (ret) mDbg = 0;
    e.take = entry; e.dbg = mDbg; e.nmiT = take; e.depc = mDepc;
    e.vec = mVec; e.cause = mCause; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0,0,0,64'h0,tag);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) check(q.pop_front());
    end
  end

  initial begin : driver
    exp_t r;
    #12;
    r.take = 0; r.dbg = 0; r.nmiT = 0; r.res = 0; r.depc = '0; r.vec = '0;
    r.cause = '0; r.tag = "R1 reset";
    check(r);
    @(negedge clk); rstN = 1;
    idle("R1 idle");
    // R2 single step, R8 rom vector
    step(1,0,1,0,0,0,0,0,64'h1000,"R2 step entry");
    idle("R2 hold");
    step(0,0,0,0,0,0,0,1,64'h0,"R12 return");
    idle("R12 after");
    // R6 real-time suppression
    step(1,0,1,0,1,0,0,0,64'h2000,"R6 step masked");
    step(0,1,1,0,1,1,0,0,64'h2004,"R6 brk masked");
    // R3 breakpoint, R7 pc capture
    step(0,1,1,0,0,0,0,0,64'h3000,"R3 brk entry");
    step(0,0,0,0,0,0,0,1,64'h0,"R12 return2");
    // R4 jtag with rt and probe vector, held through return -> R13
    step(0,0,0,1,1,1,0,0,64'h4000,"R4 jtag entry");
    step(0,0,0,1,1,1,0,1,64'h4100,"R13 return held");
    step(0,0,0,1,1,0,0,0,64'h4200,"R13 reentry");
    step(0,0,0,0,0,0,0,1,64'h0,"R13 return");
    // R5 priority
    step(1,1,1,1,0,1,0,0,64'h5000,"R5 all three");
    step(0,0,0,0,0,0,0,1,64'h0,"R5 ret");
    step(1,1,1,0,0,1,0,0,64'h5100,"R5 brk over step");
    // R9 requests ignored in debug mode
    step(1,1,1,1,0,0,0,0,64'h6000,"R9 ignored");
    idle("R9 hold");
    step(0,0,0,0,0,0,0,1,64'h0,"R9 ret");
    // R10 nmi outside debug
    step(0,0,0,0,0,0,1,0,64'h0,"R10 nmi");
    idle("R10 after");
    // R11 nmi during debug
    step(0,1,1,0,0,0,0,0,64'h7000,"R11 enter");
    step(0,0,0,0,0,0,1,0,64'h0,"R11 nmi held");
    idle("R11 masked");
    step(0,0,0,0,0,0,0,1,64'h0,"R11 return");
    idle("R11 nmi delivered");
    idle("R11 once");
    // R11 nmi in entry cycle
    step(1,0,1,0,0,0,1,0,64'h8000,"R11 nmi at entry");
    step(0,0,0,0,0,0,0,1,64'h0,"R11 return2");
    idle("R11 delivered2");
    idle("R11 quiet");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule